// File: doc/BRIEF.md
# Whole-Track Floppy Capture and Playback Controller

This block records or replays one complete floppy track through a single on-chip byte memory. The host and the internal engines share one auto-incrementing memory pointer. The host reaches the memory through a single data port, and every access moves the pointer forward. Options are written through an option port, and what a write there means depends on where the pointer currently sits. No separate option registers are needed.

A capture stores one byte per read-data pulse. The low seven bits hold the number of sample-clock ticks since the previous pulse, saturating at 127. The top bit can carry the state of the index line. A capture can begin at once, at the start of an index pulse, or right after the 16-bit sync word. It always ends when the last memory address has been filled.

Playback turns each byte into a pulse spacing on the write-bit output. It stops on a stop code. At the end of memory it wraps around instead of stopping. Playback is only accepted after a fixed unlock sequence of pointer moves.

Top module: `trackcap_ctrl`

## Requirements
- R1: `host_addr` selects a port: 0 memory, 1 abort, 2 status, 3 option, 4 start A, 5 start B. Reading or writing port 0 accesses memory at the pointer and then advances the pointer by one, wrapping at the memory size. Read data appears on `host_rdata` after the next rising clock edge.
- R2: Writing the value 0x00 to the abort port sets the pointer to 0. It changes nothing else.
- R3: Reading the abort port ends any capture or playback in progress. The pointer keeps its value.
- R4: A write to the option port with the pointer at 0 selects the drive clock on `clk_sel`. Value 0x00 gives code 0 (14 MHz), 0x80 gives code 1 (28 MHz) and 0xC0 gives code 2 (56 MHz).
- R5: A write to the option port with the pointer at 2 does three things: it allows index storing, copies bit 5 to `irq_en`, and copies bit 6 to `predecode_en`. Writing 0x00 with the pointer at 3 forbids index storing. After reset, index storing is allowed and `irq_en`, `predecode_en` and `clk_sel` are 0.
- R6: Each stored capture byte is built as follows. Bits 6:0 hold the number of sample ticks since the previous stored pulse, or since the capture began, counting the tick that carries the pulse, saturating at 127. Bit 7 is 1 only when index storing is allowed and `idx_n` is low on the storing tick.
- R7: Reading start port A begins a capture at the current pointer, starting with the next sample tick.
- R8: Reading start port B with index storing forbidden arms a capture. The capture starts on the sample tick where `idx_n` goes low. It ends, by itself, on the tick where `idx_n` returns high after the next index pulse has begun. Pulses outside that window are not stored.
- R9: Reading start port B with index storing allowed arms a capture. Sample ticks shift `rd_pulse` into a 16-bit register, MSB first. The capture begins right after that register equals 0x4489. None of the sync bits are stored.
- R10: A capture ends after it stores into the last memory address. The pointer then wraps to 0.
- R11: Playback is armed as follows: write 0x80 to the option port while the pointer is 1, then reach pointer 7 using only memory reads. A write to start port B at pointer 7 then starts playback. Any of these clears the arming first: a memory write, an abort-port clear, a memory read at pointer 7 or above, or another option write at pointer 1.
- R12: Playback takes bytes from the pointer upward. For a byte of value v (bits 6:0, 0 treated as 1), it emits a one-cycle `wr_pulse` on the v-th sample tick after loading the byte. A byte 0xFF ends playback. At the end of memory the pointer wraps to 0 and playback continues.
- R13: Reading the status port returns bit 7 = 0 while a capture is armed or running, bit 6 = 0 while playback runs, and 0 in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host port select |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid after the strobe edge |
| smp_en | input | 1 | Sample-clock tick enable |
| rd_pulse | input | 1 | Raw read-data pulse, sampled on ticks |
| idx_n | input | 1 | Index line, low while the index hole passes |
| wr_pulse | output | 1 | Write-data pulse during playback |
| clk_sel | output | 2 | Selected drive clock code |
| irq_en | output | 1 | Stored interrupt enable option |
| predecode_en | output | 1 | Stored predecode option |

## Verification
The hardest case to reach is the playback wrap. It needs the unlock sequence to have landed exactly on pointer 7, and then enough non-stop bytes to carry the pointer past the top of memory and onto a stop code at address 1. The bench writes the whole memory first, replays the unlock sequence through the ports, and counts write pulses over enough ticks to cover the wrap. A second unlock attempt with one memory write inserted must produce no playback. Index-gated capture is driven with pulses before, inside and after the window, so the opening and closing edges are both observed at the memory contents.

// File: rtl/trackcap_pkg.sv
package trackcap_pkg;

   typedef enum logic [2:0] {
      PORT_MEM     = 3'd0,
      PORT_ABORT   = 3'd1,
      PORT_STATUS  = 3'd2,
      PORT_OPTION  = 3'd3,
      PORT_START_A = 3'd4,
      PORT_START_B = 3'd5
   } port_e;

   typedef enum logic [1:0] {
      CLK_14 = 2'd0,
      CLK_28 = 2'd1,
      CLK_56 = 2'd2
   } clk_sel_e;

   // pointer slots that give the option port its meaning
   localparam int SLOT_CLOCK   = 0;
   localparam int SLOT_UNLOCK  = 1;
   localparam int SLOT_MODE    = 2;
   localparam int SLOT_NOINDEX = 3;
   localparam int SLOT_ARMED   = 7;
   localparam logic [7:0] UNLOCK_KEY = 8'h80;

endpackage

// File: rtl/tc_ram.sv
module tc_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
      if (re) rdata <= store[addr];
   end
endmodule

// File: rtl/tc_reader.sv
module tc_reader #(
   parameter int                CNT_W     = 7,
   parameter int                SYNC_W    = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h4489
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             rd_pulse,
   input  logic             idx_n,
   input  logic             start_free,
   input  logic             start_gated,
   input  logic             idx_store,
   input  logic             abort,
   input  logic             at_last,
   output logic             busy,
   output logic             st_we,
   output logic [CNT_W:0]   st_data
);
   typedef enum logic [2:0] {
      R_IDLE, R_WAIT_IDX, R_WAIT_SYNC, R_CAP, R_CAP_IDX, R_CAP_IDX2
   } rstate_e;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   rstate_e           state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_inc;
   logic              idx_q;
   logic              idx_fall;
   logic              idx_rise;
   logic              capturing;
   logic              process;
   logic [SYNC_W-1:0] shreg;
   logic [SYNC_W-1:0] sh_next;

   always_comb begin
      idx_fall  = smp_en &  idx_q & ~idx_n;
      idx_rise  = smp_en & ~idx_q &  idx_n;
      capturing = (state == R_CAP) || (state == R_CAP_IDX) || (state == R_CAP_IDX2);
      cnt_inc   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      process   = capturing && smp_en && !abort && !((state == R_CAP_IDX2) && idx_rise);
      st_we     = process && rd_pulse;
      st_data   = {idx_store & ~idx_n, cnt_inc};
      sh_next   = {shreg[SYNC_W-2:0], rd_pulse};
      busy      = (state != R_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= 1'b1;
      end else if (smp_en) begin
         idx_q <= idx_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= R_IDLE;
         cnt   <= '0;
         shreg <= '0;
      end else if (abort) begin
         state <= R_IDLE;
      end else begin
         case (state)
            R_IDLE: begin
               if (start_free) begin
                  state <= R_CAP;
                  cnt   <= '0;
               end else if (start_gated) begin
                  shreg <= '0;
                  state <= idx_store ? R_WAIT_SYNC : R_WAIT_IDX;
               end
            end
            R_WAIT_IDX: begin
               if (idx_fall) begin
                  state <= R_CAP_IDX;
                  cnt   <= '0;
               end
            end
            R_WAIT_SYNC: begin
               if (smp_en) begin
                  shreg <= sh_next;
                  if (sh_next == SYNC_WORD) begin
                     state <= R_CAP;
                     cnt   <= '0;
                  end
               end
            end
            default: begin
               if ((state == R_CAP_IDX2) && idx_rise) begin
                  state <= R_IDLE;
               end else if (smp_en) begin
                  cnt <= rd_pulse ? '0 : cnt_inc;
                  if (rd_pulse && at_last) begin
                     state <= R_IDLE;
                  end else if ((state == R_CAP_IDX) && idx_fall) begin
                     state <= R_CAP_IDX2;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tc_writer.sv
module tc_writer #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] STOP_CODE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              smp_en,
   input  logic [DATA_W-1:0] rdata,
   output logic              fetch,
   output logic              busy,
   output logic              wr_pulse
);
   localparam int CW = DATA_W - 1;
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   typedef enum logic [1:0] {W_IDLE, W_FETCH, W_LOAD, W_RUN} wstate_e;

   wstate_e       state;
   logic [CW-1:0] wcnt;

   assign fetch = (state == W_FETCH) && !abort;
   assign busy  = (state != W_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= W_IDLE;
         wcnt     <= ONE;
         wr_pulse <= 1'b0;
      end else begin
         wr_pulse <= 1'b0;
         if (abort) begin
            state <= W_IDLE;
         end else begin
            case (state)
               W_IDLE:  if (start) state <= W_FETCH;
               W_FETCH: state <= W_LOAD;
               W_LOAD: begin
                  if (rdata == STOP_CODE) begin
                     state <= W_IDLE;
                  end else begin
                     wcnt  <= (rdata[CW-1:0] == '0) ? ONE : rdata[CW-1:0];
                     state <= W_RUN;
                  end
               end
               default: begin
                  if (smp_en) begin
                     if (wcnt == ONE) begin
                        wr_pulse <= 1'b1;
                        state    <= W_FETCH;
                     end else begin
                        wcnt <= wcnt - 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/trackcap_ctrl.sv
module trackcap_ctrl
   import trackcap_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter int                DATA_W    = 8,
   parameter int                SYNC_W    = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h4489,
   parameter logic [DATA_W-1:0] STOP_CODE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              smp_en,
   input  logic              rd_pulse,
   input  logic              idx_n,
   output logic              wr_pulse,
   output logic [1:0]        clk_sel,
   output logic              irq_en,
   output logic              predecode_en
);
   localparam int                CNT_W   = DATA_W - 1;
   localparam logic [ADDR_W-1:0] P_CLOCK = ADDR_W'(SLOT_CLOCK);
   localparam logic [ADDR_W-1:0] P_UNLK  = ADDR_W'(SLOT_UNLOCK);
   localparam logic [ADDR_W-1:0] P_MODE  = ADDR_W'(SLOT_MODE);
   localparam logic [ADDR_W-1:0] P_NOIDX = ADDR_W'(SLOT_NOINDEX);
   localparam logic [ADDR_W-1:0] P_ARMED = ADDR_W'(SLOT_ARMED);
   localparam logic [ADDR_W-1:0] P_LAST  = {ADDR_W{1'b1}};

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("trackcap_ctrl: ADDR_W must reach pointer slot 7");
      end
      if (DATA_W != 8) begin : g_bad_data_w
         $error("trackcap_ctrl: option codes need DATA_W of 8");
      end
      if (SYNC_W < 2) begin : g_bad_sync_w
         $error("trackcap_ctrl: SYNC_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr;
   logic              r_busy, w_busy, busy;
   logic              st_we;
   logic [DATA_W-1:0] st_data;
   logic              w_fetch;
   logic [DATA_W-1:0] ram_q;
   logic              mem_rd, mem_wr, host_step;
   logic              ptr_clr, abort_rd, opt_wr;
   logic              start_a, start_b_rd, start_w;
   logic              at_last;
   logic              idx_store;
   logic              we_ok;
   logic              rsel_mem_q;
   logic [DATA_W-1:0] misc_q;
   logic [DATA_W-1:0] status;

   always_comb begin
      busy       = r_busy | w_busy;
      mem_rd     = host_rd && (host_addr == PORT_MEM) && !busy;
      mem_wr     = host_wr && (host_addr == PORT_MEM) && !busy;
      host_step  = mem_rd | mem_wr;
      ptr_clr    = host_wr && (host_addr == PORT_ABORT) && (host_wdata == '0);
      abort_rd   = host_rd && (host_addr == PORT_ABORT);
      opt_wr     = host_wr && (host_addr == PORT_OPTION);
      start_a    = host_rd && (host_addr == PORT_START_A) && !busy;
      start_b_rd = host_rd && (host_addr == PORT_START_B) && !busy;
      start_w    = host_wr && (host_addr == PORT_START_B) && !busy && we_ok && (ptr == P_ARMED);
      at_last    = (ptr == P_LAST);
      status     = {~r_busy, ~w_busy, {(DATA_W-2){1'b0}}};
   end

   // shared pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ptr <= '0;
      else if (ptr_clr)                          ptr <= '0;
      else if (host_step || st_we || w_fetch)    ptr <= ptr + 1'b1;
   end

   // pointer-selected options
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel      <= CLK_14;
         irq_en       <= 1'b0;
         predecode_en <= 1'b0;
         idx_store    <= 1'b1;
      end else if (opt_wr) begin
         if (ptr == P_CLOCK) begin
            case (host_wdata[7:6])
               2'b00:   clk_sel <= CLK_14;
               2'b10:   clk_sel <= CLK_28;
               2'b11:   clk_sel <= CLK_56;
               default: clk_sel <= clk_sel;
            endcase
         end else if (ptr == P_MODE) begin
            idx_store    <= 1'b1;
            irq_en       <= host_wdata[5];
            predecode_en <= host_wdata[6];
         end else if ((ptr == P_NOIDX) && (host_wdata == '0)) begin
            idx_store <= 1'b0;
         end
      end
   end

   // playback unlock tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_ok <= 1'b0;
      end else if (opt_wr && (ptr == P_UNLK)) begin
         we_ok <= (host_wdata == UNLOCK_KEY);
      end else if (ptr_clr || mem_wr || start_w || st_we || w_fetch ||
                   (mem_rd && (ptr >= P_ARMED))) begin
         we_ok <= 1'b0;
      end
   end

   // host read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_mem_q <= 1'b0;
         misc_q     <= '0;
      end else if (host_rd) begin
         rsel_mem_q <= (host_addr == PORT_MEM);
         misc_q     <= (host_addr == PORT_STATUS) ? status : '0;
      end
   end

   assign host_rdata = rsel_mem_q ? ram_q : misc_q;

   tc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (mem_wr | st_we),
      .re    (mem_rd | w_fetch),
      .addr  (ptr),
      .wdata (st_we ? st_data : host_wdata),
      .rdata (ram_q)
   );

   tc_reader #(.CNT_W(CNT_W), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_reader (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_en      (smp_en),
      .rd_pulse    (rd_pulse),
      .idx_n       (idx_n),
      .start_free  (start_a),
      .start_gated (start_b_rd),
      .idx_store   (idx_store),
      .abort       (abort_rd),
      .at_last     (at_last),
      .busy        (r_busy),
      .st_we       (st_we),
      .st_data     (st_data)
   );

   tc_writer #(.DATA_W(DATA_W), .STOP_CODE(STOP_CODE)) u_writer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_w),
      .abort    (abort_rd),
      .smp_en   (smp_en),
      .rdata    (ram_q),
      .fetch    (w_fetch),
      .busy     (w_busy),
      .wr_pulse (wr_pulse)
   );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ptr,
   input logic              host_step,
   input logic              ptr_clr,
   input logic              abort_rd,
   input logic              r_busy,
   input logic              w_busy,
   input logic              st_we,
   input logic [DATA_W-1:0] st_data,
   input logic              at_last,
   input logic              wr_pulse
);
   assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      host_step && !ptr_clr |=> ptr == $past(ptr) + 1'b1);

   assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_clr |=> ptr == '0);

   assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
      abort_rd && !ptr_clr |=> !r_busy && !w_busy && ptr == $past(ptr));

   assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> st_data[DATA_W-2:0] != '0);

   assert_full_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_we && at_last && !ptr_clr |=> !r_busy && ptr == '0);

   assert_pulse_in_play_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(w_busy));

   assert_one_engine_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_busy && w_busy));
endmodule

bind trackcap_ctrl tc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr       (ptr),
   .host_step (host_step),
   .ptr_clr   (ptr_clr),
   .abort_rd  (abort_rd),
   .r_busy    (r_busy),
   .w_busy    (w_busy),
   .st_we     (st_we),
   .st_data   (st_data),
   .at_last   (at_last),
   .wr_pulse  (wr_pulse)
);

// File: tb/trackcap_ctrl_bench.sv
module trackcap_ctrl_bench;
   localparam int AW    = 5;
   localparam int DEPTH = 1 << AW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic       host_rd = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       smp_en = 1'b0;
   logic       rd_pulse = 1'b0;
   logic       idx_n = 1'b1;
   logic       wr_pulse;
   logic [1:0] clk_sel;
   logic       irq_en;
   logic       predecode_en;

   int errors = 0;
   int checks = 0;
   logic [7:0] mem_m [DEPTH];
   logic done = 1'b0;

   always #10 clk = ~clk;

   trackcap_ctrl #(.ADDR_W(AW)) u_trackcap_ctrl (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .smp_en(smp_en), .rd_pulse(rd_pulse), .idx_n(idx_n), .wr_pulse(wr_pulse),
      .clk_sel(clk_sel), .irq_en(irq_en), .predecode_en(predecode_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [2:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hr(input logic [2:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic tick(input logic rd, input logic ix, output logic seen);
      smp_en = 1'b1; rd_pulse = rd; idx_n = ix;
      @(negedge clk);
      smp_en = 1'b0; rd_pulse = 1'b0;
      seen = wr_pulse;
      repeat (3) @(negedge clk);
   endtask

   task automatic to_ptr(input int p);
      logic [7:0] d;
      hw(3'd1, 8'h00);
      for (int i = 0; i < p; i++) hr(3'd0, d);
   endtask

   task automatic unlock();
      logic [7:0] d;
      hw(3'd1, 8'h00);
      hr(3'd0, d);
      hw(3'd3, 8'h80);
      for (int i = 0; i < 6; i++) hr(3'd0, d);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      logic       s;
      int         n;
      int         ivl [5];
      int         pulses [3];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 / R5: reset state
      hr(3'd2, d);
      chk("R13 reset status", d, 8'hC0);
      chk("R5 reset irq_en", irq_en, 0);
      chk("R5 reset predecode_en", predecode_en, 0);
      chk("R4 reset clk_sel", clk_sel, 0);

      // R1 / R2: fill and read back the whole memory
      hw(3'd1, 8'h00);
      for (int i = 0; i < DEPTH; i++) begin
         mem_m[i] = 8'((i * 37 + 5) & 8'hFE);
         hw(3'd0, mem_m[i]);
      end
      hw(3'd1, 8'h00);
      for (int i = 0; i < DEPTH; i++) begin
         hr(3'd0, d);
         chk("R1 memory readback", d, mem_m[i]);
      end
      hr(3'd0, d);
      chk("R1 pointer wraps", d, mem_m[0]);
      hw(3'd1, 8'h00);
      hr(3'd0, d);
      chk("R2 abort clears pointer", d, mem_m[0]);

      // R4: clock codes at pointer 0
      hw(3'd1, 8'h00);
      hw(3'd3, 8'h80); @(negedge clk);
      chk("R4 clock 28", clk_sel, 1);
      hw(3'd3, 8'hC0); @(negedge clk);
      chk("R4 clock 56", clk_sel, 2);
      hw(3'd3, 8'h00); @(negedge clk);
      chk("R4 clock 14", clk_sel, 0);

      // R5: mode bits at pointer 2, forbid at pointer 3
      to_ptr(2);
      hw(3'd3, 8'h60); @(negedge clk);
      chk("R5 irq_en set", irq_en, 1);
      chk("R5 predecode set", predecode_en, 1);
      hw(3'd3, 8'h20); @(negedge clk);
      chk("R5 predecode clear", predecode_en, 0);
      to_ptr(3);
      hw(3'd3, 8'h00);
      to_ptr(2);
      hw(3'd3, 8'h00); @(negedge clk);
      chk("R5 irq_en clear", irq_en, 0);

      // R7 / R6 / R3: unconditional capture with index flag and saturation
      ivl = '{3, 1, 5, 2, 130};
      hw(3'd1, 8'h00);
      hr(3'd4, d);
      hr(3'd2, d);
      chk("R13 status while reading", d, 8'h40);
      for (int j = 0; j < 5; j++) begin
         for (int k = 1; k < ivl[j]; k++) tick(1'b0, 1'b1, s);
         tick(1'b1, (j == 2) ? 1'b0 : 1'b1, s);
         mem_m[j] = {(j == 2) ? 1'b1 : 1'b0, 7'((ivl[j] > 127) ? 127 : ivl[j])};
      end
      hr(3'd1, d);
      hr(3'd2, d);
      chk("R3 abort stops capture", d, 8'hC0);
      hr(3'd0, d);
      chk("R3 pointer kept by abort", d, mem_m[5]);
      hw(3'd1, 8'h00);
      for (int j = 0; j < 5; j++) begin
         hr(3'd0, d);
         chk("R6 R7 captured byte", d, mem_m[j]);
      end

      // R9: sync-gated capture
      hw(3'd1, 8'h00);
      hr(3'd5, d);
      for (int b = 0; b < 8; b++) tick(1'b0, 1'b1, s);
      hr(3'd2, d);
      chk("R9 armed shows reading", d, 8'h40);
      for (int b = 15; b >= 0; b--) tick(1'(16'h4489 >> b), 1'b1, s);
      tick(1'b0, 1'b1, s); tick(1'b1, 1'b1, s);
      for (int b = 0; b < 3; b++) tick(1'b0, 1'b1, s);
      tick(1'b1, 1'b1, s);
      mem_m[0] = 8'd2; mem_m[1] = 8'd4;
      hr(3'd1, d);
      hr(3'd0, d);
      chk("R9 only two stored", d, mem_m[2]);
      hw(3'd1, 8'h00);
      hr(3'd0, d);
      chk("R9 sync not stored, first", d, mem_m[0]);
      hr(3'd0, d);
      chk("R9 second byte", d, mem_m[1]);

      // R8: index-gated capture with storing forbidden
      to_ptr(3);
      hw(3'd3, 8'h00);
      hw(3'd1, 8'h00);
      hr(3'd5, d);
      tick(1'b0, 1'b1, s); tick(1'b1, 1'b1, s);
      tick(1'b0, 1'b0, s);
      tick(1'b0, 1'b0, s);
      tick(1'b0, 1'b1, s);
      tick(1'b1, 1'b1, s);
      tick(1'b0, 1'b1, s); tick(1'b1, 1'b1, s);
      tick(1'b0, 1'b0, s);
      tick(1'b1, 1'b0, s);
      tick(1'b0, 1'b1, s);
      hr(3'd2, d);
      chk("R8 stops at index end", d, 8'hC0);
      tick(1'b1, 1'b1, s);
      mem_m[0] = 8'd3; mem_m[1] = 8'd2; mem_m[2] = 8'd2;
      hr(3'd0, d);
      chk("R8 nothing after window", d, mem_m[3]);
      hw(3'd1, 8'h00);
      for (int j = 0; j < 3; j++) begin
         hr(3'd0, d);
         chk("R8 R5 window byte, flag forbidden", d, mem_m[j]);
      end

      // R10: capture stops when memory is full
      hw(3'd1, 8'h00);
      hr(3'd4, d);
      for (int j = 0; j < DEPTH; j++) begin
         tick(1'b1, 1'b1, s);
         mem_m[j] = 8'd1;
      end
      hr(3'd2, d);
      chk("R10 capture ended at full", d, 8'hC0);
      tick(1'b1, 1'b1, s);
      hr(3'd0, d);
      chk("R10 pointer wrapped", d, mem_m[0]);
      for (int j = 1; j < DEPTH; j++) begin
         hr(3'd0, d);
         chk("R10 full memory", d, mem_m[j]);
      end

      // R11 / R12: playback with stop code
      hw(3'd1, 8'h00);
      for (int i = 0; i < DEPTH; i++) begin
         mem_m[i] = (i == 7) ? 8'd3 : (i == 8) ? 8'd1 : (i == 9) ? 8'd2 :
                    (i == 10) ? 8'hFF : 8'd5;
         hw(3'd0, mem_m[i]);
      end
      unlock();
      hw(3'd5, 8'h00);
      repeat (3) @(negedge clk);
      hr(3'd2, d);
      chk("R13 status while writing", d, 8'h80);
      n = 0;
      pulses = '{0, 0, 0};
      for (int t = 1; t <= 12; t++) begin
         tick(1'b0, 1'b1, s);
         if (s) begin
            if (n < 3) pulses[n] = t;
            n++;
         end
      end
      chk("R12 pulse count", n, 3);
      chk("R12 first spacing", pulses[0], 3);
      chk("R12 second spacing", pulses[1], 4);
      chk("R12 third spacing", pulses[2], 6);
      hr(3'd2, d);
      chk("R12 stop code ends playback", d, 8'hC0);

      // R11: broken unlock sequence does not start playback
      hw(3'd1, 8'h00);
      hr(3'd0, d);
      hw(3'd3, 8'h80);
      for (int i = 0; i < 3; i++) hr(3'd0, d);
      hw(3'd0, 8'h05);
      hr(3'd0, d); hr(3'd0, d);
      hw(3'd5, 8'h00);
      repeat (3) @(negedge clk);
      n = 0;
      for (int t = 0; t < 6; t++) begin
         tick(1'b0, 1'b1, s);
         if (s) n++;
      end
      hr(3'd2, d);
      chk("R11 no playback without unlock", d, 8'hC0);
      chk("R11 no pulses without unlock", n, 0);

      // R12: wrap through address 0 to stop at address 1
      hw(3'd1, 8'h00);
      for (int i = 0; i < DEPTH; i++) begin
         mem_m[i] = (i == 1) ? 8'hFF : 8'd1;
         hw(3'd0, mem_m[i]);
      end
      unlock();
      hw(3'd5, 8'h00);
      repeat (3) @(negedge clk);
      n = 0;
      for (int t = 0; t < 40; t++) begin
         tick(1'b0, 1'b1, s);
         if (s) n++;
      end
      chk("R12 wrap pulse count", n, DEPTH - 7 + 1);
      hr(3'd2, d);
      chk("R12 wrap then stop", d, 8'hC0);

      // R3: abort during playback
      unlock();
      hw(3'd5, 8'h00);
      repeat (3) @(negedge clk);
      for (int t = 0; t < 3; t++) tick(1'b0, 1'b1, s);
      hr(3'd1, d);
      n = 0;
      for (int t = 0; t < 5; t++) begin
         tick(1'b0, 1'b1, s);
         if (s) n++;
      end
      chk("R3 no pulses after abort", n, 0);
      hr(3'd2, d);
      chk("R3 playback stopped", d, 8'hC0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule